// File: doc/BRIEF.md
# Adaptive Three-Link Memory Request Selector

This block sits between an accelerator and three memory links and picks a link for every cacheline request. One link passes through an on-chip coherent cache. The other two bypass it. For each request the block receives a block ID, a six-way block type and a cacheline count. The block type is looked up upstream. It combines a locality level with a flag that says whether the block must always use the same link.

The block keeps a direct-mapped shadow of the cache's tags and types, and a pending-cacheline counter for each link. It computes a candidate link for every decision case in parallel with the shadow lookup. A final arbiter picks one candidate, and the grant appears one clock after the request. Hazard-prone blocks are steered by their low ID bits, so every access to such a block uses the same link. Free blocks are steered by comparing link loads against programmable slack thresholds, weighing the reuse value of the incoming block against the block it would evict.

Top module: `steer_top`

## Requirements
- R1: After reset, `grant_valid` is low, all pending counters are zero and every shadow entry is empty.
- R2: A request sampled with `req_valid` high produces `grant_valid` high in the next cycle, and `grant_valid` is low after a cycle without a request. `grant_link` codes are 0 = bypass link A, 1 = bypass link B and 2 = cached link; code 3 never appears. `req_kind[1:0]` gives locality (0 high, 1 medium, 2 or 3 low), and `req_kind[2]` = 1 marks a fixed-link block.
- R3: A shadow hit selects the cached link whatever the type. A miss whose new locality is high also selects the cached link.
- R4: On a miss with a low-locality fixed-link type, `req_id[0]` = 0 selects link A and 1 selects link B.
- R5: On a miss with a medium-locality fixed-link type, `req_id[1:0]` of 00 or 01 selects the cached link, 10 selects link A and 11 selects link B.
- R6: A shadow entry is written, with the request's tag and type, only on a miss that is granted to the cached link. An empty entry reports low locality as its resident type.
- R7: Let `LU` be the bypass link with the smaller pending count (link A on a tie). On a miss with a free new type of low or medium locality, and a resident type of high or medium locality, the block picks the cached link when its count plus the slack strictly undercuts `LU`'s count, and `LU` otherwise. Low new types use `slack_lo_keep`; medium new types use `slack_md_keep`.
- R8: On a miss with a medium free new type and a low resident type, the block picks `LU` when `LU`'s count plus `slack_md_take` is strictly below the cached link's count, and the cached link otherwise.
- R9: On a miss with a low free new type and a low resident type, the block picks the link with the smallest count. Ties are broken in the order link A, link B, cached link.
- R10: A granted request adds `req_lines` to its link's counter. A completion subtracts `cpl_lines` from the counter of `cpl_link`, and both can apply in one cycle. A counter clamps at zero and at its maximum instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slack_lo_keep | input | CNT_W | Slack for a low free new block against a high or medium resident block |
| slack_md_keep | input | CNT_W | Slack for a medium free new block against a high or medium resident block |
| slack_md_take | input | CNT_W | Slack for a medium free new block against a low resident block |
| req_valid | input | 1 | Request present this cycle |
| req_id | input | ID_W | Requested block ID |
| req_kind | input | 3 | Block type: bit 2 fixed-link, bits 1:0 locality |
| req_lines | input | LINE_W | Cachelines in the request |
| cpl_valid | input | 1 | Completion present this cycle |
| cpl_link | input | 2 | Link the completion returned on |
| cpl_lines | input | LINE_W | Cachelines completed |
| grant_valid | output | 1 | Registered grant strobe |
| grant_link | output | 2 | Registered chosen link |

## Verification
A stale or wrongly written shadow entry turns a later request into a false hit or a false miss. That shows up as a cached-link grant where a bypass link was expected, or the reverse, on the first request that revisits the set. A drifting pending counter moves the slack and minimum comparisons, so the scenarios drive the counts to exact equality with and without the slack. A one-count error then flips the very next grant. Clamping at zero is shown by draining more lines than are pending and then seeing tie-order grants.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [1:0] {
    LINK_UA = 2'd0,
    LINK_UB = 2'd1,
    LINK_C  = 2'd2
  } link_e;

  localparam logic [1:0] LOC_HI = 2'd0;
  localparam logic [1:0] LOC_MD = 2'd1;

  // Low locality covers codes 2 and 3.
  function automatic logic loc_is_low(input logic [2:0] kind);
    return kind[1];
  endfunction

  function automatic logic loc_is_md(input logic [2:0] kind);
    return kind[1:0] == LOC_MD;
  endfunction

  function automatic logic loc_is_hi(input logic [2:0] kind);
    return kind[1:0] == LOC_HI;
  endfunction
endpackage

// File: rtl/steer_shadow.sv
module steer_shadow #(
  parameter int ID_W = 16,
  parameter int SETS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] look_id,
  input  logic            wr_en,
  input  logic [2:0]      wr_kind,
  output logic            hit,
  output logic [2:0]      old_kind
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ID_W - IDX_W;

  logic [SETS-1:0]  ent_vld;
  logic [TAG_W-1:0] ent_tag  [SETS];
  logic [2:0]       ent_kind [SETS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = look_id[IDX_W-1:0];
  assign tag = look_id[ID_W-1:IDX_W];

  always_comb begin
    hit      = ent_vld[idx] && (ent_tag[idx] == tag);
    old_kind = ent_vld[idx] ? ent_kind[idx] : 3'b010;
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic set_we;
    assign set_we = wr_en && (idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_vld[s] <= 1'b0;
      else if (set_we) ent_vld[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (set_we) begin
        ent_tag[s]  <= tag;
        ent_kind[s] <= wr_kind;
      end
    end
  end
endmodule

// File: rtl/steer_loadtrack.sv
module steer_loadtrack #(
  parameter int CNT_W  = 10,
  parameter int LINE_W = 4,
  parameter int NLINK  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINK-1:0]  inc_en,
  input  logic [LINE_W-1:0] inc_lines,
  input  logic [NLINK-1:0]  dec_en,
  input  logic [LINE_W-1:0] dec_lines,
  output logic [CNT_W-1:0]  cnt [NLINK]
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

  for (genvar l = 0; l < NLINK; l++) begin : g_link
    logic [SUM_W-1:0] up, sub, diff;
    logic [CNT_W-1:0] cnt_d;
    logic             cnt_en;

    always_comb begin
      up     = SUM_W'(cnt[l]) + (inc_en[l] ? SUM_W'(inc_lines) : '0);
      sub    = dec_en[l] ? SUM_W'(dec_lines) : '0;
      diff   = up - sub;
      cnt_en = inc_en[l] || dec_en[l];
      if (up < sub)           cnt_d = '0;
      else if (diff > CNT_MAX) cnt_d = {CNT_W{1'b1}};
      else                    cnt_d = diff[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt[l] <= '0;
      else if (cnt_en) cnt[l] <= cnt_d;
    end
  end
endmodule

// File: rtl/steer_pick.sv
module steer_pick
  import steer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             hit,
  input  logic [2:0]       kind_new,
  input  logic [2:0]       kind_old,
  input  logic [1:0]       id_lsb,
  input  logic [CNT_W-1:0] cnt_c,
  input  logic [CNT_W-1:0] cnt_ua,
  input  logic [CNT_W-1:0] cnt_ub,
  input  logic [CNT_W-1:0] slk_lo_keep,
  input  logic [CNT_W-1:0] slk_md_keep,
  input  logic [CNT_W-1:0] slk_md_take,
  output link_e            link
);
  localparam int CMP_W = CNT_W + 1;

  link_e            lu;
  logic [CNT_W-1:0] cnt_lu;
  link_e            cand_fix_lo, cand_fix_md, cand_keep_lo, cand_keep_md;
  link_e            cand_take, cand_min;

  // Pre-selection: every candidate is formed without waiting for the lookup.
  always_comb begin
    lu     = (cnt_ua <= cnt_ub) ? LINK_UA : LINK_UB;
    cnt_lu = (cnt_ua <= cnt_ub) ? cnt_ua : cnt_ub;

    cand_fix_lo = id_lsb[0] ? LINK_UB : LINK_UA;
    if (!id_lsb[1])     cand_fix_md = LINK_C;
    else if (id_lsb[0]) cand_fix_md = LINK_UB;
    else                cand_fix_md = LINK_UA;

    cand_keep_lo = (CMP_W'(cnt_c) + CMP_W'(slk_lo_keep) < CMP_W'(cnt_lu)) ? LINK_C : lu;
    cand_keep_md = (CMP_W'(cnt_c) + CMP_W'(slk_md_keep) < CMP_W'(cnt_lu)) ? LINK_C : lu;
    cand_take    = (CMP_W'(cnt_lu) + CMP_W'(slk_md_take) < CMP_W'(cnt_c)) ? lu : LINK_C;

    if (cnt_ua <= cnt_ub && cnt_ua <= cnt_c) cand_min = LINK_UA;
    else if (cnt_ub <= cnt_c)                cand_min = LINK_UB;
    else                                     cand_min = LINK_C;
  end

  // Final arbitration once hit and types are known.
  always_comb begin
    if (hit || loc_is_hi(kind_new))               link = LINK_C;
    else if (kind_new[2] && loc_is_low(kind_new)) link = cand_fix_lo;
    else if (kind_new[2])                         link = cand_fix_md;
    else if (!loc_is_low(kind_old))
      link = loc_is_low(kind_new) ? cand_keep_lo : cand_keep_md;
    else
      link = loc_is_md(kind_new) ? cand_take : cand_min;
  end
endmodule

// File: rtl/steer_top.sv
module steer_top
  import steer_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int SETS   = 16,
  parameter int CNT_W  = 10,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  slack_lo_keep,
  input  logic [CNT_W-1:0]  slack_md_keep,
  input  logic [CNT_W-1:0]  slack_md_take,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [2:0]        req_kind,
  input  logic [LINE_W-1:0] req_lines,
  input  logic              cpl_valid,
  input  logic [1:0]        cpl_link,
  input  logic [LINE_W-1:0] cpl_lines,
  output logic              grant_valid,
  output logic [1:0]        grant_link
);
  localparam int NLINK = 3;

  logic             sh_hit;
  logic [2:0]       sh_old_kind;
  link_e            sel_link;
  logic             sh_wr;
  logic [NLINK-1:0] inc_en, dec_en;
  logic [CNT_W-1:0] cnt [NLINK];
  logic [CNT_W-1:0] cnt_ua, cnt_ub, cnt_c;
  logic             grant_valid_d;
  logic [1:0]       grant_link_d;

  assign cnt_ua = cnt[0];
  assign cnt_ub = cnt[1];
  assign cnt_c  = cnt[2];

  steer_shadow #(.ID_W(ID_W), .SETS(SETS)) u_shadow (
    .clk(clk), .rst_n(rst_n), .look_id(req_id), .wr_en(sh_wr),
    .wr_kind(req_kind), .hit(sh_hit), .old_kind(sh_old_kind)
  );

  steer_pick #(.CNT_W(CNT_W)) u_pick (
    .hit(sh_hit), .kind_new(req_kind), .kind_old(sh_old_kind),
    .id_lsb(req_id[1:0]), .cnt_c(cnt_c), .cnt_ua(cnt_ua), .cnt_ub(cnt_ub),
    .slk_lo_keep(slack_lo_keep), .slk_md_keep(slack_md_keep),
    .slk_md_take(slack_md_take), .link(sel_link)
  );

  always_comb begin
    sh_wr = req_valid && !sh_hit && (sel_link == LINK_C);
    for (int l = 0; l < NLINK; l++) begin
      inc_en[l] = req_valid && (sel_link == link_e'(l));
      dec_en[l] = cpl_valid && (cpl_link == 2'(l));
    end
  end

  steer_loadtrack #(.CNT_W(CNT_W), .LINE_W(LINE_W), .NLINK(NLINK)) u_load (
    .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .inc_lines(req_lines),
    .dec_en(dec_en), .dec_lines(cpl_lines), .cnt(cnt)
  );

  always_comb begin
    grant_valid_d = req_valid;
    grant_link_d  = req_valid ? sel_link : grant_link;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_link  <= 2'd0;
    end else begin
      grant_valid <= grant_valid_d;
      grant_link  <= grant_link_d;
    end
  end
endmodule

// File: rtl/steer_top_chk.sv
module steer_top_chk #(
  parameter int ID_W  = 16,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [ID_W-1:0]  req_id,
  input logic [2:0]       req_kind,
  input logic             cpl_valid,
  input logic             sh_hit,
  input logic [CNT_W-1:0] cnt_ua,
  input logic [CNT_W-1:0] cnt_ub,
  input logic [CNT_W-1:0] cnt_c,
  input logic             grant_valid,
  input logic [1:0]       grant_link
);
  assert_grant_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> grant_valid);

  assert_grant_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !grant_valid);

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant_link != 2'd3);

  assert_hit_cached_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sh_hit) |=> grant_link == 2'd2);

  assert_fixlo_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sh_hit && req_kind[2] && req_kind[1])
      |=> grant_link == {1'b0, $past(req_id[0])});

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !cpl_valid)
      |=> ($stable(cnt_ua) && $stable(cnt_ub) && $stable(cnt_c)));
endmodule

bind steer_top steer_top_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
  .req_kind(req_kind), .cpl_valid(cpl_valid), .sh_hit(sh_hit),
  .cnt_ua(cnt_ua), .cnt_ub(cnt_ub), .cnt_c(cnt_c),
  .grant_valid(grant_valid), .grant_link(grant_link)
);

// File: tb/steer_top_test.sv
module steer_top_test;
  localparam int ID_W = 16, CNT_W = 10, LINE_W = 4;
  localparam logic [2:0] K_HI_FREE = 3'b000, K_MD_FREE = 3'b001, K_LO_FREE = 3'b010;
  localparam logic [2:0] K_MD_FIX = 3'b101, K_LO_FIX = 3'b110;
  localparam logic [1:0] UA = 2'd0, UB = 2'd1, CL = 2'd2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CNT_W-1:0]  slack_lo_keep, slack_md_keep, slack_md_take;
  logic              req_valid, cpl_valid;
  logic [ID_W-1:0]   req_id;
  logic [2:0]        req_kind;
  logic [LINE_W-1:0] req_lines, cpl_lines;
  logic [1:0]        cpl_link;
  logic              grant_valid;
  logic [1:0]        grant_link;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  steer_top #(.ID_W(ID_W), .SETS(16), .CNT_W(CNT_W), .LINE_W(LINE_W)) uut (
    .clk(clk), .rst_n(rst_n), .slack_lo_keep(slack_lo_keep),
    .slack_md_keep(slack_md_keep), .slack_md_take(slack_md_take),
    .req_valid(req_valid), .req_id(req_id), .req_kind(req_kind),
    .req_lines(req_lines), .cpl_valid(cpl_valid), .cpl_link(cpl_link),
    .cpl_lines(cpl_lines), .grant_valid(grant_valid), .grant_link(grant_link)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Request with optional same-cycle completion; checks the grant one cycle later.
  task automatic send(input string req, input logic [ID_W-1:0] id, input logic [2:0] kind,
                      input int lines, input logic [1:0] exp, input bit with_cpl = 1'b0,
                      input logic [1:0] clink = 2'd0, input int clines = 0);
    @(negedge clk);
    req_valid = 1'b1; req_id = id; req_kind = kind; req_lines = LINE_W'(lines);
    cpl_valid = with_cpl; cpl_link = clink; cpl_lines = LINE_W'(clines);
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
    check({req, " grant_valid"}, int'(grant_valid), 1);
    check({req, " grant_link"}, int'(grant_link), int'(exp));
  endtask

  task automatic complete(input logic [1:0] link, input int lines);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_link = link; cpl_lines = LINE_W'(lines);
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0; req_id = '0; req_kind = '0;
    req_lines = '0; cpl_link = '0; cpl_lines = '0;
    slack_lo_keep = 10'd8; slack_md_keep = 10'd8; slack_md_take = 10'd8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset grant_valid", int'(grant_valid), 0);
    // Empty array and zero counts: low free, empty set, tie -> link A.
    send("R1 zero counts tie", 16'h0003, K_LO_FREE, 1, UA);
    @(negedge clk);
    check("R2 idle grant_valid", int'(grant_valid), 0);
  endtask

  task automatic t_hit_and_high;
    send("R3 high miss", 16'h0010, K_HI_FREE, 1, CL);
    send("R3 hit", 16'h0010, K_LO_FREE, 1, CL);
  endtask

  task automatic t_fixed_low;
    send("R4 lsb1", 16'h0021, K_LO_FIX, 1, UB);
    send("R4 lsb0", 16'h0022, K_LO_FIX, 1, UA);
    // Not written on bypass grant: miss, empty set, min is link B (1 vs A 2, C 2).
    send("R6 no write on bypass", 16'h0021, K_LO_FREE, 1, UB);
  endtask

  task automatic t_fixed_med;
    send("R5 lsb00", 16'h0034, K_MD_FIX, 1, CL);
    send("R5 lsb01", 16'h0035, K_MD_FIX, 1, CL);
    send("R5 lsb10", 16'h0036, K_MD_FIX, 1, UA);
    send("R5 lsb11", 16'h0037, K_MD_FIX, 1, UB);
  endtask

  task automatic t_drain;
    complete(UA, 15); complete(UB, 15); complete(CL, 15);
    // Clamped at zero: all equal, low free on empty set -> link A.
    send("R10 clamp at zero", 16'h0003, K_LO_FREE, 1, UA);
    complete(UA, 1);
  endtask

  task automatic t_keep_rules;
    send("R4 load A", 16'h0022, K_LO_FIX, 10, UA);
    send("R4 load B", 16'h0021, K_LO_FIX, 10, UB);
    send("R7 low new vs high old", 16'h0020, K_LO_FREE, 1, CL);   // 0+8<10
    send("R7 low new vs med old", 16'h0044, K_LO_FREE, 1, CL);    // 1+8<10
    send("R7 equality boundary", 16'h0045, K_LO_FREE, 1, UA);     // 2+8=10
  endtask

  task automatic t_take_rule;
    send("R8 small cached load", 16'h0030, K_MD_FREE, 1, CL);     // old low, 10+8 !< 2
    send("R3 load cached", 16'h0050, K_HI_FREE, 15, CL);           // c=18
    send("R8 equality boundary", 16'h0054, K_MD_FREE, 1, CL);     // 10+8 !< 18
    send("R6 empty old is low", 16'h0062, K_MD_FREE, 1, UB);       // 10+8 < 19
    send("R7 med new vs high old", 16'h0070, K_MD_FREE, 1, UA);    // 19+8 !< 11
  endtask

  task automatic t_min_rule;
    send("R9 min link B", 16'h0081, K_LO_FREE, 1, UB);             // A12 B11 C19
    send("R9 tie A first", 16'h0091, K_LO_FREE, 1, UA, 1'b1, UA, 2); // A12 B12
    send("R10 issue and completion", 16'h00a1, K_LO_FREE, 1, UA);  // A11 B12
  endtask

  initial begin
    t_reset();
    t_hit_and_high();
    t_fixed_low();
    t_fixed_med();
    t_drain();
    t_keep_rules();
    t_take_rule();
    t_min_rule();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule